// File: doc/BRIEF.md
# Three-Output Playback Mixing Matrix

This block sits in the digital playback path in front of the output converters. Each sample period it takes one signed left and one signed right playback sample and one signed beep sample, and forms three signed output streams. The left line stream mixes only the left playback sample with the beep. The right line stream mixes only the right playback sample with the beep. The mono speaker stream adds left and right together with the beep. Each of the three mixes scales the beep through its own gain code. The mono stream then passes through an output gain stage and a mute. A second, negated copy of the mono result is produced so that the two mono outputs can drive the two halves of a differential pair.

All inputs move on one valid strobe. The gain codes and the mute are static control inputs that are sampled together with the data. Every sum is formed with enough guard bits to be exact and is then clamped to the signed sample range. The results are registered and appear one clock after the strobe, marked by an output strobe.

Top module: `pbmix_top`

## Requirements
- R1: `line_l` equals sat(`dac_l` + beep_scaled(`gain_beep_l`)), where sat clamps to the signed DW-bit range.
- R2: `line_r` equals sat(`dac_r` + beep_scaled(`gain_beep_r`)).
- R3: With `mono_mute` low, `spk_p` equals sat((`dac_l` + `dac_r` + beep_scaled(`gain_beep_m`)) × 2^`gain_mono`). The sum is exact before the clamp, and `gain_mono` code g gives +6·g dB.
- R4: For a beep gain code c, code 0 contributes zero. A code c > 0 contributes `beep` arithmetically shifted right by (2^BGW − 1 − c), so the top code is unity gain and each step down is −6 dB.
- R5: Every output saturates to the range −2^(DW−1) .. 2^(DW−1)−1 and does not wrap.
- R6: `spk_n` equals −`spk_p`. When `spk_p` is −2^(DW−1), `spk_n` is 2^(DW−1)−1.
- R7: With `mono_mute` high, `spk_p` and `spk_n` are both 0, and `line_l` and `line_r` are unaffected.
- R8: Outputs captured on a clock edge with `in_valid` high are visible after that edge. `out_valid` is high for exactly the cycles that follow a cycle with `in_valid` high.
- R9: While `in_valid` is low, all four data outputs hold their values whatever the data and control inputs do.
- R10: While `rst_n` is low, all data outputs are 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| dac_l | input | DW | Left playback sample, signed |
| dac_r | input | DW | Right playback sample, signed |
| beep | input | DW | Beep sample, signed |
| gain_beep_l | input | BGW | Beep gain code for the left line stream |
| gain_beep_r | input | BGW | Beep gain code for the right line stream |
| gain_beep_m | input | BGW | Beep gain code for the mono stream |
| gain_mono | input | MGW | Mono output gain code, +6 dB per step |
| mono_mute | input | 1 | Forces both mono outputs to zero |
| out_valid | output | 1 | Output sample strobe |
| line_l | output | DW | Left line result, signed |
| line_r | output | DW | Right line result, signed |
| spk_p | output | DW | Mono result, positive half |
| spk_n | output | DW | Mono result, negated half |

## Verification
There is one register stage between the inputs and every output. The line results, the two mono results and `out_valid` are therefore all due at the first rising edge after the cycle in which `in_valid` is high. The bench drives each sample on a falling edge, lowers the strobe on the next falling edge and reads all outputs there, half a cycle after the capturing edge. The hold checks wait two further full cycles with the strobe low before reading again, and the reset checks read while reset is still asserted.

// File: rtl/pbmix_pkg.sv
package pbmix_pkg;

   // Default data width of one sample word.
   localparam int PBMIX_DW_DEF  = 24;
   // Default width of a beep gain code (6 dB per step).
   localparam int PBMIX_BGW_DEF = 4;
   // Default width of the mono output gain code (6 dB per step).
   localparam int PBMIX_MGW_DEF = 2;

   // Number of playback channels feeding each kind of mix.
   localparam int PBMIX_LINE_SRCS = 1;
   localparam int PBMIX_MONO_SRCS = 2;

endpackage

// File: rtl/pbmix_beep_scale.sv
module pbmix_beep_scale #(
   parameter int DW  = 24,
   parameter int BGW = 4,
   parameter int OW  = 26
) (
   input  logic signed [DW-1:0]  beep,
   input  logic        [BGW-1:0] code,
   output logic signed [OW-1:0]  scaled
);

   localparam int MAXC = (2 ** BGW) - 1;

   logic signed [OW-1:0]  beep_ext;
   logic        [BGW-1:0] shamt;

   assign beep_ext = {{(OW-DW){beep[DW-1]}}, beep};
   assign shamt    = BGW'(MAXC) - code;

   always_comb begin
      if (code == '0) begin
         scaled = '0;
      end else begin
         scaled = beep_ext >>> shamt;
      end
   end

endmodule

// File: rtl/pbmix_sat.sv
module pbmix_sat #(
   parameter int IW = 29,
   parameter int OW = 24
) (
   input  logic signed [IW-1:0] din,
   output logic signed [OW-1:0] dout
);

   localparam logic signed [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
   localparam logic signed [IW-1:0] LO = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

   always_comb begin
      if (din > HI) begin
         dout = HI[OW-1:0];
      end else if (din < LO) begin
         dout = LO[OW-1:0];
      end else begin
         dout = din[OW-1:0];
      end
   end

endmodule

// File: rtl/pbmix_negsat.sv
module pbmix_negsat #(
   parameter int DW = 24
) (
   input  logic signed [DW-1:0] a,
   output logic signed [DW-1:0] y
);

   localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
   localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

   always_comb begin
      if (a == MINV) begin
         y = MAXV;
      end else begin
         y = -a;
      end
   end

endmodule

// File: rtl/pbmix_path.sv
module pbmix_path #(
   parameter int DW  = 24,
   parameter int BGW = 4,
   parameter int MGW = 2,
   parameter int NIN = 1
) (
   input  logic        [NIN-1:0][DW-1:0] dac,
   input  logic signed [DW-1:0]          beep,
   input  logic        [BGW-1:0]         beep_code,
   input  logic        [MGW-1:0]         gain_code,
   input  logic                          mute,
   output logic signed [DW-1:0]          y
);

   // Guard bits for NIN playback terms plus the beep term.
   localparam int GB    = $clog2(NIN + 1);
   localparam int SW    = DW + GB;
   localparam int MAXSH = (2 ** MGW) - 1;
   localparam int WW    = SW + MAXSH;

   logic signed [SW-1:0] beep_w;
   logic signed [SW-1:0] acc [NIN+1];
   logic signed [WW-1:0] acc_ext;
   logic signed [WW-1:0] gained;
   logic signed [DW-1:0] clamped;

   pbmix_beep_scale #(
      .DW  (DW),
      .BGW (BGW),
      .OW  (SW)
   ) u_beep (
      .beep   (beep),
      .code   (beep_code),
      .scaled (beep_w)
   );

   assign acc[0] = beep_w;

   for (genvar gi = 0; gi < NIN; gi++) begin : g_src
      logic signed [SW-1:0] src_ext;
      assign src_ext   = {{GB{dac[gi][DW-1]}}, dac[gi]};
      assign acc[gi+1] = acc[gi] + src_ext;
   end

   assign acc_ext = {{MAXSH{acc[NIN][SW-1]}}, acc[NIN]};

   always_comb begin
      gained = acc_ext <<< gain_code;
   end

   pbmix_sat #(
      .IW (WW),
      .OW (DW)
   ) u_sat (
      .din  (gained),
      .dout (clamped)
   );

   assign y = mute ? '0 : clamped;

endmodule

// File: rtl/pbmix_top.sv
module pbmix_top
   import pbmix_pkg::*;
#(
   parameter int DW  = PBMIX_DW_DEF,
   parameter int BGW = PBMIX_BGW_DEF,
   parameter int MGW = PBMIX_MGW_DEF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [DW-1:0]  dac_l,
   input  logic [DW-1:0]  dac_r,
   input  logic [DW-1:0]  beep,
   input  logic [BGW-1:0] gain_beep_l,
   input  logic [BGW-1:0] gain_beep_r,
   input  logic [BGW-1:0] gain_beep_m,
   input  logic [MGW-1:0] gain_mono,
   input  logic           mono_mute,
   output logic           out_valid,
   output logic [DW-1:0]  line_l,
   output logic [DW-1:0]  line_r,
   output logic [DW-1:0]  spk_p,
   output logic [DW-1:0]  spk_n
);

   // Elaboration-time parameter checks.
   if (DW < 8 || DW > 32) begin : g_bad_dw
      $error("pbmix_top: DW must lie in 8..32");
   end
   if (BGW < 2 || BGW > 5) begin : g_bad_bgw
      $error("pbmix_top: BGW must lie in 2..5");
   end
   if (MGW < 1 || MGW > 3) begin : g_bad_mgw
      $error("pbmix_top: MGW must lie in 1..3");
   end

   logic [DW-1:0] mix_l;
   logic [DW-1:0] mix_r;
   logic [DW-1:0] mix_m;
   logic [DW-1:0] mix_m_neg;

   pbmix_path #(
      .DW  (DW),
      .BGW (BGW),
      .MGW (MGW),
      .NIN (PBMIX_LINE_SRCS)
   ) u_path_l (
      .dac       (dac_l),
      .beep      (beep),
      .beep_code (gain_beep_l),
      .gain_code ('0),
      .mute      (1'b0),
      .y         (mix_l)
   );

   pbmix_path #(
      .DW  (DW),
      .BGW (BGW),
      .MGW (MGW),
      .NIN (PBMIX_LINE_SRCS)
   ) u_path_r (
      .dac       (dac_r),
      .beep      (beep),
      .beep_code (gain_beep_r),
      .gain_code ('0),
      .mute      (1'b0),
      .y         (mix_r)
   );

   pbmix_path #(
      .DW  (DW),
      .BGW (BGW),
      .MGW (MGW),
      .NIN (PBMIX_MONO_SRCS)
   ) u_path_m (
      .dac       ({dac_r, dac_l}),
      .beep      (beep),
      .beep_code (gain_beep_m),
      .gain_code (gain_mono),
      .mute      (mono_mute),
      .y         (mix_m)
   );

   pbmix_negsat #(
      .DW (DW)
   ) u_neg (
      .a (mix_m),
      .y (mix_m_neg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         line_l    <= '0;
         line_r    <= '0;
         spk_p     <= '0;
         spk_n     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            line_l <= mix_l;
            line_r <= mix_r;
            spk_p  <= mix_m;
            spk_n  <= mix_m_neg;
         end
      end
   end

endmodule

// File: rtl/pbmix_chk.sv
module pbmix_chk #(
   parameter int DW  = 24,
   parameter int BGW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic [DW-1:0]  dac_l,
   input logic [BGW-1:0] gain_beep_l,
   input logic           mono_mute,
   input logic           out_valid,
   input logic [DW-1:0]  line_l,
   input logic [DW-1:0]  line_r,
   input logic [DW-1:0]  spk_p,
   input logic [DW-1:0]  spk_n
);

   localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

   // R8
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(line_l) && $stable(line_r) && $stable(spk_p) && $stable(spk_n)));

   // R7
   mono_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mono_mute) |=> (spk_p == '0 && spk_n == '0));

   // R4
   beep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && gain_beep_l == '0) |=> (line_l == $past(dac_l)));

   // R6
   diff_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((spk_p == MINV) ? (spk_n == MAXV) : (spk_n == DW'(-spk_p))));

endmodule

bind pbmix_top pbmix_chk #(
   .DW  (DW),
   .BGW (BGW)
) u_pbmix_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .dac_l       (dac_l),
   .gain_beep_l (gain_beep_l),
   .mono_mute   (mono_mute),
   .out_valid   (out_valid),
   .line_l      (line_l),
   .line_r      (line_r),
   .spk_p       (spk_p),
   .spk_n       (spk_n)
);

// File: tb/pbmix_top_bench.sv
module pbmix_top_bench;

   localparam int DW  = 24;
   localparam int BGW = 4;
   localparam int MGW = 2;

   typedef struct packed {
      logic [23:0] l;
      logic [23:0] r;
      logic [23:0] b;
      logic [3:0]  gl;
      logic [3:0]  gr;
      logic [3:0]  gm;
      logic [1:0]  mg;
      logic        mute;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{24'h000100, 24'h000200, 24'h001000, 4'd15, 4'd14, 4'd0,  2'd0, 1'b0},
      '{24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 4'd15, 4'd15, 4'd15, 2'd0, 1'b0},
      '{24'h800000, 24'h800000, 24'h800000, 4'd15, 4'd15, 4'd0,  2'd0, 1'b0},
      '{24'h001234, 24'hFFF000, 24'hFFFFFF, 4'd14, 4'd1,  4'd13, 2'd1, 1'b0},
      '{24'h000400, 24'h000300, 24'h000100, 4'd0,  4'd0,  4'd12, 2'd3, 1'b0},
      '{24'h0FFFFF, 24'h000001, 24'h000000, 4'd7,  4'd7,  4'd7,  2'd3, 1'b0},
      '{24'h123456, 24'h654321, 24'h400000, 4'd15, 4'd13, 4'd15, 2'd2, 1'b1},
      '{24'hC00000, 24'hC00000, 24'h000000, 4'd1,  4'd2,  4'd0,  2'd0, 1'b0},
      '{24'hFFFF00, 24'h0000FF, 24'h80000F, 4'd11, 4'd15, 4'd14, 2'd0, 1'b0},
      '{24'h000005, 24'hFFFFFB, 24'h00000A, 4'd2,  4'd9,  4'd5,  2'd2, 1'b0}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [DW-1:0]  dac_l = '0;
   logic [DW-1:0]  dac_r = '0;
   logic [DW-1:0]  beep = '0;
   logic [BGW-1:0] gain_beep_l = '0;
   logic [BGW-1:0] gain_beep_r = '0;
   logic [BGW-1:0] gain_beep_m = '0;
   logic [MGW-1:0] gain_mono = '0;
   logic           mono_mute = 1'b0;
   logic           out_valid;
   logic [DW-1:0]  line_l;
   logic [DW-1:0]  line_r;
   logic [DW-1:0]  spk_p;
   logic [DW-1:0]  spk_n;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   pbmix_top #(
      .DW  (DW),
      .BGW (BGW),
      .MGW (MGW)
   ) u_pbmix_top (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .dac_l       (dac_l),
      .dac_r       (dac_r),
      .beep        (beep),
      .gain_beep_l (gain_beep_l),
      .gain_beep_r (gain_beep_r),
      .gain_beep_m (gain_beep_m),
      .gain_mono   (gain_mono),
      .mono_mute   (mono_mute),
      .out_valid   (out_valid),
      .line_l      (line_l),
      .line_r      (line_r),
      .spk_p       (spk_p),
      .spk_n       (spk_n)
   );

   // Reference model, written from the requirements.
   function automatic longint sx(input logic [23:0] v);
      return longint'(signed'(v));
   endfunction

   function automatic longint beep_sc(input logic [23:0] b, input logic [3:0] c);
      if (c == 4'd0) return 0;
      return sx(b) >>> (15 - int'(c));
   endfunction

   function automatic longint sat24(input longint x);
      if (x > 64'sd8388607) return 8388607;
      if (x < -64'sd8388608) return -8388608;
      return x;
   endfunction

   function automatic longint mono_of(input vec_t v);
      if (v.mute) return 0;
      return sat24((sx(v.l) + sx(v.r) + beep_sc(v.b, v.gm)) * (longint'(1) << v.mg));
   endfunction

   function automatic longint neg_of(input longint m);
      if (m == -8388608) return 8388607;
      return -m;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      dac_l       = v.l;
      dac_r       = v.r;
      beep        = v.b;
      gain_beep_l = v.gl;
      gain_beep_r = v.gr;
      gain_beep_m = v.gm;
      gain_mono   = v.mg;
      mono_mute   = v.mute;
   endtask

   // Drive at a falling edge with the strobe high; read half a cycle after capture.
   task automatic apply(input vec_t v);
      @(negedge clk);
      drive(v);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      longint hl;
      longint hr;
      longint hp;
      longint hn;
      vec_t   w;

      // R10: reset state while reset is held
      repeat (3) @(negedge clk);
      chk("R10 out_valid", longint'(out_valid), 0);
      chk("R10 line_l", sx(line_l), 0);
      chk("R10 line_r", sx(line_r), 0);
      chk("R10 spk_p", sx(spk_p), 0);
      chk("R10 spk_n", sx(spk_n), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         chk("R8 out_valid high", longint'(out_valid), 1);
         chk("R1 line_l", sx(line_l), sat24(sx(VECS[i].l) + beep_sc(VECS[i].b, VECS[i].gl)));
         chk("R2 line_r", sx(line_r), sat24(sx(VECS[i].r) + beep_sc(VECS[i].b, VECS[i].gr)));
         chk("R3 spk_p", sx(spk_p), mono_of(VECS[i]));
         chk("R6 spk_n", sx(spk_n), neg_of(mono_of(VECS[i])));
      end

      // R8: strobe low gives out_valid low one cycle later
      @(negedge clk);
      chk("R8 out_valid low", longint'(out_valid), 0);

      // R5: saturation corners
      w = '{24'h7FFFF0, 24'h000000, 24'h000100, 4'd15, 4'd15, 4'd15, 2'd3, 1'b0};
      apply(w);
      chk("R5 line_l clamps high", sx(line_l), 8388607);
      chk("R5 spk_p clamps high", sx(spk_p), 8388607);
      chk("R6 spk_n of max", sx(spk_n), -8388607);
      w = '{24'h800000, 24'h800000, 24'h800000, 4'd15, 4'd15, 4'd15, 2'd0, 1'b0};
      apply(w);
      chk("R5 line_r clamps low", sx(line_r), -8388608);
      chk("R6 spk_n of min", sx(spk_n), 8388607);

      // R4: beep gain code 0 leaves the playback sample untouched, top code is unity
      w = '{24'h000010, 24'h000020, 24'h7FFFFF, 4'd0, 4'd15, 4'd0, 2'd0, 1'b0};
      apply(w);
      chk("R4 code 0 mutes beep", sx(line_l), 16);
      chk("R4 unity code", sx(line_r), 8388607);
      chk("R4 mono code 0", sx(spk_p), 48);
      w = '{24'h000000, 24'h000000, 24'h7FFFFF, 4'd14, 4'd1, 4'd3, 2'd0, 1'b0};
      apply(w);
      chk("R4 code 14", sx(line_l), 24'h3FFFFF);
      chk("R4 code 1", sx(line_r), 24'h1FF);
      chk("R4 code 3", sx(spk_p), 24'h7FF);

      // R7: mute silences mono, lines unaffected
      w = '{24'h000300, 24'h000500, 24'h000000, 4'd0, 4'd0, 4'd0, 2'd1, 1'b1};
      apply(w);
      chk("R7 spk_p muted", sx(spk_p), 0);
      chk("R7 spk_n muted", sx(spk_n), 0);
      chk("R7 line_l kept", sx(line_l), 24'h300);
      chk("R7 line_r kept", sx(line_r), 24'h500);

      // R9: with the strobe low, new inputs change nothing
      hl = sx(line_l);
      hr = sx(line_r);
      hp = sx(spk_p);
      hn = sx(spk_n);
      @(negedge clk);
      drive('{24'h111111, 24'h222222, 24'h333333, 4'd15, 4'd15, 4'd15, 2'd3, 1'b0});
      repeat (2) @(negedge clk);
      chk("R9 line_l hold", sx(line_l), hl);
      chk("R9 line_r hold", sx(line_r), hr);
      chk("R9 spk_p hold", sx(spk_p), hp);
      chk("R9 spk_n hold", sx(spk_n), hn);
      chk("R9 out_valid low", longint'(out_valid), 0);

      // R10: reset in mid-run clears the outputs
      apply(VECS[1]);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 mid-run line_l", sx(line_l), 0);
      chk("R10 mid-run spk_n", sx(spk_n), 0);
      chk("R10 mid-run out_valid", longint'(out_valid), 0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule